// File: doc/BRIEF.md
# Self-Calibration Sequencer with Data-Ready Flag

This block sequences a converter front end through its self-calibration and conversion steps. A host writes a 3-bit mode field. Code `001` starts a self-calibration on the channel presented at the time of the write. Code `000` selects plain conversion. Every other code is refused and changes nothing.

During a calibration the block drives an input-path select. It first shorts the input pair internally and takes the zero-scale reading. It then switches to the internal reference-derived level and takes the full-scale reading. Finally it returns to the analog input for a normal conversion. Each phase is timed in output-valid strobes from the digital filter, and the third strobe after a path switch is the first settled one. The settled zero-scale and full-scale words leave the block through write pulses, together with the channel and the data, and go into the per-channel coefficient registers.

The mode field falls back to `000` as soon as the full-scale word is stored, after six strobes. An active-low ready flag goes high on the clock after any accepted write. It goes low again only when a fresh conversion word is published, which happens nine strobes after a calibration command. The flag goes high again when the host reads the word.

The controller has four named states:
- `ST_SETTLE`: conversion on the input, discarding settling words.
- `ST_ZERO`: shorted input.
- `ST_FULL`: reference level.
- `ST_RUN`: every strobe is published.

Its transitions are:
- Any state goes to `ST_ZERO` on an accepted `001` write.
- Any state goes to `ST_SETTLE` on an accepted `000` write.
- `ST_ZERO` goes to `ST_FULL` on the third strobe.
- `ST_FULL` goes to `ST_SETTLE` on the third strobe.
- `ST_SETTLE` goes to `ST_RUN` on the third strobe.

Top module: `cal_seq`

## Requirements
- R1: An accepted write of code `001` latches `chan_sel`. From the next cycle it shows `mode_q` = `001` and `in_sel` = `01` (shorted input).
- R2: In the zero-scale phase, the third strobe produces a one-cycle `zs_we` pulse on the next cycle. The pulse carries `coef_ch` = the latched channel and `coef_data` = that strobe's `flt_data`. Earlier strobes produce no pulse.
- R3: After the zero-scale phase, `in_sel` = `10` (reference level). The third strobe there produces a one-cycle `fs_we` pulse with that strobe's data.
- R4: `mode_q` returns to `000` in the same cycle that `fs_we` is asserted, six strobes after the command.
- R5: `data_rdy_n` is high in the cycle after any accepted mode write, whatever its earlier level.
- R6: `data_rdy_n` falls only together with a fresh word in `data_out`. After a calibration this happens on the ninth strobe.
- R7: A mode write with any code other than `000` or `001` leaves `mode_q`, `in_sel`, `data_rdy_n` and the sequence unchanged.
- R8: An accepted write during a calibration restarts the strobe count. Code `001` restarts from the zero-scale phase and code `000` goes to conversion settling. A strobe in the same cycle as an accepted write is discarded.
- R9: A read (`data_rd`) while a word is pending sets `data_rdy_n` high on the next cycle.
- R10: Once settled, every strobe overwrites `data_out` and leaves `data_rdy_n` low. A read in the same cycle as a strobe leaves the flag low with the new word.
- R11: After every path switch, the first two strobes are discarded. `in_sel` is `00` (analog input) outside the two calibration phases.
- R12: After reset, `mode_q` = `000`, `in_sel` = `00`, `data_rdy_n` = 1, `data_out` = 0, no write pulse, and the block is settling a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Mode field write strobe |
| mode_wdata | input | 3 | Mode code written |
| chan_sel | input | CHAN_W | Channel for the sequence, latched on an accepted write |
| flt_valid | input | 1 | Filter output-valid strobe |
| flt_data | input | DATA_W | Filter output word |
| data_rd | input | 1 | Host read of the data word |
| mode_q | output | 3 | Current mode field |
| in_sel | output | 2 | Input path: 00 input, 01 shorted, 10 reference |
| data_out | output | DATA_W | Last published conversion word |
| data_rdy_n | output | 1 | Active-low data-ready flag |
| zs_we | output | 1 | Zero-scale coefficient write pulse |
| fs_we | output | 1 | Full-scale coefficient write pulse |
| coef_ch | output | CHAN_W | Channel of the coefficient write |
| coef_data | output | DATA_W | Coefficient word |

## Verification
The ready flag can be released by a host read and pulled low by a freshly published word in the same cycle. Likewise, a mode write can coincide with a filter strobe. The bench provokes both collisions on purpose: it drives a read together with a steady-state strobe, and a restart write together with a strobe in the middle of the full-scale phase. A behavioural model, which gives the publish and the write priority, is compared against the flag, data word, mode field and write pulses on every clock.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
    typedef enum logic [1:0] {
        ST_SETTLE = 2'd0,
        ST_ZERO   = 2'd1,
        ST_FULL   = 2'd2,
        ST_RUN    = 2'd3
    } seq_state_t;

    localparam logic [2:0] MODE_CONV    = 3'b000;
    localparam logic [2:0] MODE_SELFCAL = 3'b001;

    localparam logic [1:0] SEL_INPUT = 2'b00;
    localparam logic [1:0] SEL_SHORT = 2'b01;
    localparam logic [1:0] SEL_REF   = 2'b10;
endpackage

// File: rtl/cal_strobe_ctr.sv
module cal_strobe_ctr #(
    parameter int SETTLE_N = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic strobe,
    output logic last
);
    localparam int CNT_W = (SETTLE_N > 1) ? $clog2(SETTLE_N) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SETTLE_N - 1);

    logic [CNT_W-1:0] cnt_q;

    assign last = strobe && (cnt_q == LAST_CNT);

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clear)  cnt_q <= '0;
        else if (last)   cnt_q <= '0;
        else if (strobe) cnt_q <= cnt_q + 1'b1;
    end

    // R11: the settling count never passes the last settling strobe
    a_r11_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_CNT);

    // R8: a clear always restarts the count from zero
    a_r8_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> cnt_q == '0);
endmodule

// File: rtl/cal_rdy_flag.sv
module cal_rdy_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic publish,
    input  logic host_rd,
    output logic rdy_n
);
    always_ff @(posedge clk) begin
        if (!rst_n)       rdy_n <= 1'b1;
        else if (arm)     rdy_n <= 1'b1;
        else if (publish) rdy_n <= 1'b0;
        else if (host_rd) rdy_n <= 1'b1;
    end

    // R5: an accepted command raises the flag
    a_r5_arm_high: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> rdy_n);

    // R6: the flag falls only with a publish
    a_r6_fall_on_publish: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_n) |-> $past(publish));

    // R9: a lone read releases the flag
    a_r9_read_release: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !arm && !publish) |=> rdy_n);
endmodule

// File: rtl/cal_seq.sv
module cal_seq
    import cal_seq_pkg::*;
#(
    parameter int DATA_W   = 24,
    parameter int CHAN_W   = 3,
    parameter int SETTLE_N = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [2:0]        mode_wdata,
    input  logic [CHAN_W-1:0] chan_sel,
    input  logic              flt_valid,
    input  logic [DATA_W-1:0] flt_data,
    input  logic              data_rd,
    output logic [2:0]        mode_q,
    output logic [1:0]        in_sel,
    output logic [DATA_W-1:0] data_out,
    output logic              data_rdy_n,
    output logic              zs_we,
    output logic              fs_we,
    output logic [CHAN_W-1:0] coef_ch,
    output logic [DATA_W-1:0] coef_data
);
    seq_state_t state_q, state_d;

    logic cmd_cal, cmd_conv, cmd_ok, cmd_bad;
    logic ctr_strobe, phase_last, publish;

    assign cmd_cal  = mode_we && (mode_wdata == MODE_SELFCAL);
    assign cmd_conv = mode_we && (mode_wdata == MODE_CONV);
    assign cmd_ok   = cmd_cal || cmd_conv;
    assign cmd_bad  = mode_we && !cmd_ok;

    assign ctr_strobe = flt_valid && !cmd_ok && (state_q != ST_RUN);

    cal_strobe_ctr #(.SETTLE_N(SETTLE_N)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (cmd_ok),
        .strobe (ctr_strobe),
        .last   (phase_last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (cmd_cal) begin
            state_d = ST_ZERO;
        end else if (cmd_conv) begin
            state_d = ST_SETTLE;
        end else if (phase_last) begin
            unique case (state_q)
                ST_ZERO:   state_d = ST_FULL;
                ST_FULL:   state_d = ST_SETTLE;
                ST_SETTLE: state_d = ST_RUN;
                ST_RUN:    state_d = ST_RUN;
                default:   state_d = ST_SETTLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SETTLE;
        else        state_q <= state_d;
    end

    // state-decoded outputs
    always_comb begin
        unique case (state_q)
            ST_ZERO: in_sel = SEL_SHORT;
            ST_FULL: in_sel = SEL_REF;
            default: in_sel = SEL_INPUT;
        endcase
        publish = flt_valid && !cmd_ok &&
                  ((state_q == ST_RUN) || ((state_q == ST_SETTLE) && phase_last));
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MODE_CONV;
            zs_we     <= 1'b0;
            fs_we     <= 1'b0;
            coef_ch   <= '0;
            coef_data <= '0;
            data_out  <= '0;
        end else begin
            zs_we <= !cmd_ok && (state_q == ST_ZERO) && phase_last;
            fs_we <= !cmd_ok && (state_q == ST_FULL) && phase_last;
            if (cmd_ok) begin
                mode_q  <= mode_wdata;
                coef_ch <= chan_sel;
            end else if ((state_q == ST_FULL) && phase_last) begin
                mode_q <= MODE_CONV;
            end
            if (!cmd_ok && phase_last &&
                ((state_q == ST_ZERO) || (state_q == ST_FULL)))
                coef_data <= flt_data;
            if (publish)
                data_out <= flt_data;
        end
    end

    cal_rdy_flag u_rdy (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (cmd_ok),
        .publish (publish),
        .host_rd (data_rd),
        .rdy_n   (data_rdy_n)
    );

    // R1: self-calibration command enters the shorted phase
    a_r1_cal_start: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_cal |=> (mode_q == MODE_SELFCAL) && (in_sel == SEL_SHORT));

    // R2: zero-scale word captured while the input was shorted
    a_r2_zs_from_short: assert property (@(posedge clk) disable iff (!rst_n)
        zs_we |-> $past(in_sel) == SEL_SHORT);

    // R3: full-scale word captured while the reference was selected
    a_r3_fs_from_ref: assert property (@(posedge clk) disable iff (!rst_n)
        fs_we |-> $past(in_sel) == SEL_REF);

    // R2, R3: at most one coefficient write per cycle
    a_r3_one_coef_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({zs_we, fs_we}));

    // R4: mode field clears from calibration only with the full-scale write
    a_r4_mode_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_q) == MODE_SELFCAL && mode_q == MODE_CONV) |-> (fs_we || $past(mode_we)));

    // R7: refused codes change nothing
    a_r7_bad_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_bad |=> $stable(mode_q) && $stable(in_sel));

    // R10: a word is published in steady state on every strobe
    a_r10_run_publish: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && flt_valid && !mode_we) |=> !data_rdy_n);
endmodule

// File: tb/tb_cal_seq.sv
module tb_cal_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 24;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_we = 1'b0;
    logic [2:0]    mode_wdata = 3'b000;
    logic [CW-1:0] chan_sel = '0;
    logic          flt_valid = 1'b0;
    logic [DW-1:0] flt_data = '0;
    logic          data_rd = 1'b0;
    logic [2:0]    mode_q;
    logic [1:0]    in_sel;
    logic [DW-1:0] data_out;
    logic          data_rdy_n;
    logic          zs_we, fs_we;
    logic [CW-1:0] coef_ch;
    logic [DW-1:0] coef_data;

    int errors = 0;
    int checks = 0;
    bit started = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cal_seq #(.DATA_W(DW), .CHAN_W(CW), .SETTLE_N(3)) dut (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .chan_sel(chan_sel), .flt_valid(flt_valid), .flt_data(flt_data),
        .data_rd(data_rd), .mode_q(mode_q), .in_sel(in_sel), .data_out(data_out),
        .data_rdy_n(data_rdy_n), .zs_we(zs_we), .fs_we(fs_we),
        .coef_ch(coef_ch), .coef_data(coef_data)
    );

    // behavioural reference: phase 0 settle, 1 zero, 2 full, 3 run
    int          m_ph = 0;
    int          m_cnt = 0;
    logic [2:0]  m_mode = 3'b000;
    logic        m_rdy = 1'b1;
    logic [DW-1:0] m_data = '0;
    logic        m_zs = 1'b0, m_fs = 1'b0;
    logic [DW-1:0] m_cdata = '0;
    logic [CW-1:0] m_ch = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_mode = 3'b000; m_rdy = 1'b1; m_data = '0;
            m_zs = 1'b0; m_fs = 1'b0; m_cdata = '0; m_ch = '0;
        end else begin
            m_zs = 1'b0; m_fs = 1'b0;
            if (mode_we && (mode_wdata == 3'b000 || mode_wdata == 3'b001)) begin
                m_mode = mode_wdata;
                m_ph = (mode_wdata == 3'b001) ? 1 : 0;
                m_cnt = 0;
                m_rdy = 1'b1;
                m_ch = chan_sel;
            end else begin
                if (data_rd) m_rdy = 1'b1;
                if (flt_valid) begin
                    if (m_ph == 3) begin
                        m_data = flt_data; m_rdy = 1'b0;
                    end else if (m_cnt < 2) begin
                        m_cnt++;
                    end else begin
                        m_cnt = 0;
                        if (m_ph == 1) begin
                            m_zs = 1'b1; m_cdata = flt_data; m_ph = 2;
                        end else if (m_ph == 2) begin
                            m_fs = 1'b1; m_cdata = flt_data; m_ph = 0; m_mode = 3'b000;
                        end else begin
                            m_data = flt_data; m_rdy = 1'b0; m_ph = 3;
                        end
                    end
                end
            end
            started = 1'b1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, got, exp);
        end
    endtask

    // per-clock comparison with the model
    always @(negedge clk) begin
        if (started && rst_n) begin
            chk("R4 mode_q", 32'(mode_q), 32'(m_mode));
            chk("R6 data_rdy_n", 32'(data_rdy_n), 32'(m_rdy));
            chk("R10 data_out", 32'(data_out), 32'(m_data));
            chk("R2 zs_we", 32'(zs_we), 32'(m_zs));
            chk("R3 fs_we", 32'(fs_we), 32'(m_fs));
            chk("R11 in_sel", 32'(in_sel), (m_ph == 1) ? 32'd1 : (m_ph == 2) ? 32'd2 : 32'd0);
            if (m_zs || m_fs) begin
                chk("R2 coef_data", 32'(coef_data), 32'(m_cdata));
                chk("R2 coef_ch", 32'(coef_ch), 32'(m_ch));
            end
        end
    end

    task automatic cyc(input logic we, input logic [2:0] code, input logic [CW-1:0] ch,
                       input logic v, input logic [DW-1:0] d, input logic rd);
        mode_we = we; mode_wdata = code; chan_sel = ch;
        flt_valid = v; flt_data = d; data_rd = rd;
        @(negedge clk);
        mode_we = 1'b0; flt_valid = 1'b0; data_rd = 1'b0;
    endtask

    task automatic strobe(input logic [DW-1:0] d);
        cyc(1'b0, 3'b000, '0, 1'b1, d, 1'b0);
        cyc(1'b0, 3'b000, '0, 1'b0, '0, 1'b0);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state
        chk("R12 mode_q", 32'(mode_q), 32'd0);
        chk("R12 data_rdy_n", 32'(data_rdy_n), 32'd1);
        chk("R12 in_sel", 32'(in_sel), 32'd0);
        chk("R12 data_out", 32'(data_out), 32'd0);

        // R11: settling after reset, third strobe publishes
        strobe(24'h000011);
        strobe(24'h000022);
        chk("R11 still pending", 32'(data_rdy_n), 32'd1);
        strobe(24'h000033);
        chk("R11 first word", 32'(data_out), 32'h33);

        // R9: read releases the flag
        cyc(1'b0, 3'b000, '0, 1'b0, '0, 1'b1);
        chk("R9 read release", 32'(data_rdy_n), 32'd1);

        // R10: steady strobes, then read and strobe together
        strobe(24'h000044);
        cyc(1'b0, 3'b000, '0, 1'b1, 24'h000055, 1'b1);
        chk("R10 read+word", 32'(data_rdy_n), 32'd0);
        chk("R10 new word", 32'(data_out), 32'h55);

        // R7: refused code
        cyc(1'b1, 3'b101, 3'd6, 1'b0, '0, 1'b0);
        chk("R7 mode kept", 32'(mode_q), 32'd0);
        chk("R7 flag kept", 32'(data_rdy_n), 32'd0);

        // R1: start self-calibration on channel 5
        cyc(1'b1, 3'b001, 3'd5, 1'b0, '0, 1'b0);
        chk("R1 mode", 32'(mode_q), 32'd1);
        chk("R1 in_sel short", 32'(in_sel), 32'd1);
        chk("R5 flag high", 32'(data_rdy_n), 32'd1);
        for (int i = 0; i < 3; i++) strobe(24'h0A0000 + 24'(i));
        chk("R3 in_sel ref", 32'(in_sel), 32'd2);
        strobe(24'h0B0000);
        // R8: restart in the full phase with a colliding strobe
        cyc(1'b1, 3'b001, 3'd2, 1'b1, 24'h0BBBBB, 1'b0);
        chk("R8 restart short", 32'(in_sel), 32'd1);
        // full run: 9 strobes with spacing
        for (int i = 0; i < 9; i++) begin
            strobe(24'h100000 + 24'(i));
            if (i == 5) chk("R4 mode cleared", 32'(mode_q), 32'd0);
            if (i == 7) chk("R6 not yet", 32'(data_rdy_n), 32'd1);
        end
        chk("R6 ninth word", 32'(data_out), 32'h100008);
        chk("R6 flag low", 32'(data_rdy_n), 32'd0);

        // R8: 000 write mid-calibration goes to settling
        cyc(1'b1, 3'b001, 3'd1, 1'b0, '0, 1'b0);
        strobe(24'h200000);
        cyc(1'b1, 3'b000, 3'd1, 1'b0, '0, 1'b0);
        chk("R8 conv input", 32'(in_sel), 32'd0);
        for (int i = 0; i < 4; i++) strobe(24'h300000 + 24'(i));
        chk("R11 settled word", 32'(data_out), 32'h300003);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(negedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule